// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Shifter

An 8-bit serial port built around one shift register with a data-in line, a data-out line and a shift clock. Software loads a byte, sets a busy flag, and the port exchanges that byte with a partner one bit per shift-clock period, most significant bit first. When the last bit has moved, the busy flag drops by itself. Software may also drop the flag early, which ends the exchange after fewer than eight bits.

As master, the port makes its own shift clock from the instruction-cycle strobe. A two-bit code picks the period: 2, 4 or 8 strobes. When the top bit of the code is set, the period is 8 and the low bit has no effect. As slave, the port follows a shift clock that a partner drives. That clock and the incoming data pass through a synchroniser before the edge detector. The clock idles low. The output bit changes on a falling edge and the input is sampled on a rising edge. The port does nothing while its enable is low. There is no chip select: framing comes only from the busy flag.

Top module: `sio_shifter`

## Requirements
- R1: After reset, sreg_o is 0x00, busy_o is 0, and sk_o and so_o are 0.
- R2: When busy_o is 0, load_i writes load_data_i into the register on the next clock. so_o always shows bit 7 of sreg_o.
- R3: As master, the shift-clock period is 2 strobes for rate code 00, 4 for code 01, and 8 for codes 10 and 11 (bit 0 is ignored). busy_o drops on the clock edge that takes the 8×period-th strobe counted after the edge that set it.
- R4: As master, sk_o rises after half a period and falls after a full period. si_i is sampled on the rising edge. The register shifts left on the falling edge, taking in the sampled bit. After eight bits it holds the received byte, first bit in bit 7.
- R5: sk_o is low in every cycle that follows a cycle with busy_o low.
- R6: Clearing busy_o after m whole bits (0<m<8) stops the transfer. The register then holds the upper byte of {tx, rx} shifted left by m.
- R7: As slave, the register shifts on edges of sk_i that have passed through a two-flop synchroniser. busy_o drops after the eighth falling edge, and the register then holds the received byte.
- R8: While busy_o is low, sk_i edges and si_i leave the register unchanged.
- R9: While en_i is low, busy_o is 0 from the next cycle on, and busy_set_i has no effect.
- R10: load_i is ignored while busy_o is 1. During a transfer, sreg_o shows the partly shifted contents.
- R11: As master, sk_o changes state only on clocks where tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle instruction-cycle strobe |
| en_i | input | 1 | Port enable |
| master_i | input | 1 | 1 = generate shift clock, 0 = follow sk_i |
| rate_i | input | 2 | Master period code: 00→2, 01→4, 1x→8 strobes |
| load_i | input | 1 | Parallel write strobe |
| load_data_i | input | 8 | Parallel write data |
| busy_set_i | input | 1 | Start a transfer |
| busy_clr_i | input | 1 | Stop a transfer (wins over set) |
| sk_i | input | 1 | External shift clock (slave) |
| si_i | input | 1 | Serial data in |
| sk_o | output | 1 | Generated shift clock (master) |
| so_o | output | 1 | Serial data out |
| sreg_o | output | 8 | Shift register contents |
| busy_o | output | 1 | Transfer in progress |

## Verification
Load and busy changes appear one clock after the strobe. A master shift-clock toggle, and the shift or busy drop that goes with it, appear on the edge that consumes the strobe. In slave mode, the response comes three clocks after an sk_i edge: two synchroniser stages plus the edge register. The bench drives all inputs on the falling clock edge and counts the strobes that land on rising edges. It checks busy_o against the 8×period rule after every edge and tracks sk_o edges to predict so_o and the partial register contents. In slave mode it holds each sk_i level for four clocks, so every comparison falls after the three-clock delay.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned MAX_HALF = 4;

  // half shift-clock period in strobes; top bit alone picks slowest rate
  function automatic logic [2:0] half_ticks(input logic [1:0] rate);
    if (rate[1])      return 3'd4;
    else if (rate[0]) return 3'd2;
    else              return 3'd1;
  endfunction
endpackage

// File: rtl/sio_master_clk.sv
module sio_master_clk
  import sio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       sk_o,
  output logic       rise_o,
  output logic       fall_o
);
  localparam int unsigned CNT_W = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic             sk_q;
  logic             wrap;

  assign wrap   = run_i && tick_i && ({1'b0, cnt_q} == half_ticks(rate_i) - 3'd1);
  assign rise_o = wrap && !sk_q;
  assign fall_o = wrap && sk_q;
  assign sk_o   = sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sk_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sk_q  <= !sk_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sio_slave_sync.sv
module sio_slave_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sk_i,
  input  logic si_i,
  output logic rise_o,
  output logic fall_o,
  output logic si_o
);
  // one extra flop on the clock path holds the previous level for edge detect
  logic [STAGES:0]   sk_q;
  logic [STAGES-1:0] si_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sk_q <= '0;
          si_q <= '0;
        end else begin
          sk_q <= {sk_q[0], sk_i};
          si_q <= si_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sk_q <= '0;
          si_q <= '0;
        end else begin
          sk_q <= {sk_q[STAGES-1:0], sk_i};
          si_q <= {si_q[STAGES-2:0], si_i};
        end
      end
    end
  endgenerate

  assign rise_o = sk_q[STAGES-1] && !sk_q[STAGES];
  assign fall_o = !sk_q[STAGES-1] && sk_q[STAGES];
  assign si_o   = si_q[STAGES-1];
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             busy_set_i,
  input  logic             busy_clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] sreg_o,
  output logic             busy_o,
  output logic             shift_o
);
  localparam int unsigned CNT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] sreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             smp_q;
  logic             keep;

  assign keep    = en_i && !busy_clr_i;
  assign shift_o = busy_q && keep && fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!keep) begin
      busy_q <= 1'b0;
    end else if (!busy_q && busy_set_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (shift_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(WIDTH - 1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      smp_q  <= 1'b0;
    end else begin
      if (busy_q && rise_i) smp_q <= bit_i;
      if (shift_o)                sreg_q <= {sreg_q[WIDTH-2:0], smp_q};
      else if (!busy_q && load_i) sreg_q <= load_data_i;
    end
  end

  assign sreg_o = sreg_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             master_i,
  input  logic [1:0]       rate_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             busy_set_i,
  input  logic             busy_clr_i,
  input  logic             sk_i,
  input  logic             si_i,
  output logic             sk_o,
  output logic             so_o,
  output logic [WIDTH-1:0] sreg_o,
  output logic             busy_o
);
  logic m_run, m_rise, m_fall;
  logic s_rise, s_fall, s_si;
  logic rise, fall, bit_in;
  logic shift_fire;

  assign m_run = en_i && master_i && busy_o;

  sio_master_clk i_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (m_run),
    .rate_i (rate_i),
    .sk_o   (sk_o),
    .rise_o (m_rise),
    .fall_o (m_fall)
  );

  sio_slave_sync #(.STAGES(SYNC_STAGES)) i_ssync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sk_i   (sk_i),
    .si_i   (si_i),
    .rise_o (s_rise),
    .fall_o (s_fall),
    .si_o   (s_si)
  );

  assign rise   = master_i ? m_rise : s_rise;
  assign fall   = master_i ? m_fall : s_fall;
  assign bit_in = master_i ? si_i   : s_si;

  sio_shift_core #(.WIDTH(WIDTH)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .busy_set_i  (busy_set_i),
    .busy_clr_i  (busy_clr_i),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .bit_i       (bit_in),
    .sreg_o      (sreg_o),
    .busy_o      (busy_o),
    .shift_o     (shift_fire)
  );

  assign so_o = sreg_o[WIDTH-1];
endmodule

// File: rtl/sio_shifter_chk.sv
module sio_shifter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             en_i,
  input logic             master_i,
  input logic             load_i,
  input logic             busy_o,
  input logic             sk_o,
  input logic [WIDTH-1:0] sreg_o,
  input logic             shift_fire
);
  AST_EN_LOW_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o); // R9

  AST_SK_IDLES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !sk_o); // R5

  AST_SK_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && master_i && !tick_i) |=> $stable(sk_o)); // R11

  AST_LOAD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_i && !shift_fire) |=> $stable(sreg_o)); // R10

  AST_IDLE_HOLDS_SREG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> $stable(sreg_o)); // R8
endmodule

bind sio_shifter sio_shifter_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .en_i       (en_i),
  .master_i   (master_i),
  .load_i     (load_i),
  .busy_o     (busy_o),
  .sk_o       (sk_o),
  .sreg_o     (sreg_o),
  .shift_fire (shift_fire)
);

// File: tb/test_sio_shifter.sv
module test_sio_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, en_i = 1'b0, master_i = 1'b0;
  logic [1:0] rate_i = 2'b00;
  logic       load_i = 1'b0, busy_set_i = 1'b0, busy_clr_i = 1'b0;
  logic [7:0] load_data_i = 8'h00;
  logic       sk_i = 1'b0, si_i = 1'b0;
  logic       sk_o, so_o, busy_o;
  logic [7:0] sreg_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #(CLK_PERIOD / 2) clk_i = !clk_i;

  sio_shifter i_sio_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .master_i(master_i), .rate_i(rate_i), .load_i(load_i),
    .load_data_i(load_data_i), .busy_set_i(busy_set_i),
    .busy_clr_i(busy_clr_i), .sk_i(sk_i), .si_i(si_i), .sk_o(sk_o),
    .so_o(so_o), .sreg_o(sreg_o), .busy_o(busy_o)
  );

  function automatic int period_of(input logic [1:0] r);
    return r[1] ? 8 : (r[0] ? 4 : 2);
  endfunction

  function automatic logic [7:0] partial(input logic [7:0] tx, input logic [7:0] rx, input int k);
    logic [15:0] w;
    w = {tx, rx} << k;
    return w[15:8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic load_byte(input logic [7:0] d);
    load_i = 1'b1; load_data_i = d;
    cyc(1);
    load_i = 1'b0;
    check("R2 load", sreg_o, d);
    check("R2 so_o msb", so_o, d[7]);
  endtask

  // m = bits before early clear (8 = full transfer)
  task automatic run_master(input logic [7:0] tx, input logic [7:0] rx, input logic [1:0] rate,
                            input int pct, input int m, input bit poke);
    int p = period_of(rate);
    int ticks = 0, k = 0, guard = 0;
    bit prev_sk = 0, ok_t = 1, ok_so = 1, ok_part = 1, clr_pend = 0, cleared = 0;
    en_i = 1'b1; master_i = 1'b1; rate_i = rate;
    load_byte(tx);
    tick_i = 1'b0; si_i = rx[7]; busy_set_i = 1'b1;
    cyc(1);
    busy_set_i = 1'b0;
    check("R3 busy set", busy_o, 1'b1);
    while (busy_o && guard < 4000) begin
      bit t;
      guard++;
      t = ($urandom % 100) < pct;
      tick_i = t;
      busy_clr_i = clr_pend; clr_pend = 0;
      load_i = poke && ($urandom % 4 == 0); load_data_i = 8'($urandom);
      cyc(1);
      if (t) ticks++;
      if (m == 8 && busy_o !== (ticks < 8 * p)) ok_t = 0;
      if (!busy_o) break;
      if (!prev_sk && sk_o && so_o !== tx[7 - k]) ok_so = 0;
      if (prev_sk && !sk_o) k++;
      if (sreg_o !== partial(tx, rx, k)) ok_part = 0;
      if (k < 8) si_i = rx[7 - k];
      if (k == m && !cleared) begin clr_pend = 1; cleared = 1; end
      prev_sk = sk_o;
    end
    tick_i = 1'b0; busy_clr_i = 1'b0; load_i = 1'b0;
    if (m == 8) check("R3 busy drops at 8*period ticks", ok_t, 1'b1);
    check("R4 so_o msb first at sk rise", ok_so, 1'b1);
    check("R10 partial contents, load ignored", ok_part, 1'b1);
    check(m == 8 ? "R4 received byte" : "R6 early clear result", sreg_o, partial(tx, rx, m));
    cyc(1);
    check("R5 sk_o idle low", sk_o, 1'b0);
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] rx, input int m);
    en_i = 1'b1; master_i = 1'b0;
    load_byte(tx);
    busy_set_i = 1'b1;
    cyc(1);
    busy_set_i = 1'b0;
    for (int k = 0; k < m; k++) begin
      si_i = rx[7 - k];
      check("R7 slave so_o", so_o, tx[7 - k]);
      cyc(4); sk_i = 1'b1;
      cyc(4); sk_i = 1'b0;
      cyc(4);
      if (k == 6) check("R7 busy held before eighth edge", busy_o, 1'b1);
    end
    if (m < 8) begin
      busy_clr_i = 1'b1; cyc(1); busy_clr_i = 1'b0;
    end
    cyc(2);
    check("R7 slave busy done", busy_o, 1'b0);
    check(m == 8 ? "R7 slave received byte" : "R6 slave early clear", sreg_o, partial(tx, rx, m));
  endtask

  initial begin
    void'($urandom(32'h5107_2024));
    cyc(3);
    check("R1 reset sreg", sreg_o, 8'h00);
    check("R1 reset busy", busy_o, 1'b0);
    check("R1 reset sk_o", sk_o, 1'b0);
    check("R1 reset so_o", so_o, 1'b0);
    rst_ni = 1'b1;
    cyc(2);

    run_master(8'hA5, 8'h3C, 2'b00, 100, 8, 0);
    run_master(8'h96, 8'hE1, 2'b01, 100, 8, 0);
    run_master(8'h5A, 8'hC3, 2'b10, 60, 8, 0);
    run_master(8'h81, 8'h7E, 2'b11, 60, 8, 1);
    run_master(8'hF0, 8'h0F, 2'b01, 100, 3, 0);
    run_master(8'hCC, 8'h33, 2'b00, 100, 1, 0);
    run_master(8'h12, 8'hED, 2'b10, 100, 7, 1);
    for (int n = 0; n < 12; n++) begin
      int mm = ($urandom % 3 == 0) ? 1 + ($urandom % 7) : 8;
      run_master(8'($urandom), 8'($urandom), 2'($urandom), 20 + ($urandom % 81), mm, bit'($urandom));
    end

    run_slave(8'hB4, 8'h69, 8);
    run_slave(8'h3E, 8'hA7, 5);

    // R8: edges with busy clear shift nothing
    master_i = 1'b0;
    load_byte(8'h5C);
    for (int i = 0; i < 3; i++) begin
      si_i = 1'($urandom); cyc(4); sk_i = 1'b1; cyc(4); sk_i = 1'b0;
    end
    cyc(5);
    check("R8 idle slave edges ignored", sreg_o, 8'h5C);
    check("R8 busy still clear", busy_o, 1'b0);

    // R9: enable low
    en_i = 1'b0; busy_set_i = 1'b1; cyc(1); busy_set_i = 1'b0; cyc(1);
    check("R9 set ignored while disabled", busy_o, 1'b0);
    en_i = 1'b1; master_i = 1'b1; rate_i = 2'b00;
    busy_set_i = 1'b1; cyc(1); busy_set_i = 1'b0;
    tick_i = 1'b1; cyc(3); tick_i = 1'b0;
    en_i = 1'b0; cyc(1);
    check("R9 enable drop clears busy", busy_o, 1'b0);
    cyc(1);
    check("R5 sk_o low after disable", sk_o, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    cyc(WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule